// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches over an embedded core and checks that it still responds in time. A free-running timebase counts clock cycles. The timeout is a power of two, 2^N cycles, where software chooses N. When the interval expires the first time, the block only warns: it sets a state bit and raises an interrupt. The core's interrupt handler is expected to clear that bit. If the bit is still set when the interval expires again, the block asserts a reset to the core for a fixed number of cycles. It then goes back to its idle counting state.

Software reaches the block through one 16-bit control and status word. A single write strobe carries the data, and the current view of the word is always present on the read port. The counter also restarts on a one-cycle kick pulse that comes from the command channel. Once the watchdog is enabled, software cannot turn it off, and the timeout exponent is frozen. A sticky cause bit records that the most recent core reset came from the watchdog. Only a system reset or a write-one-to-clear removes it.

Top module: `wdog_dual`

## Requirements
- R1: After the system reset `rst_n` is released, the read word is 16'h1400: enable bit0 = 0, state bit1 = 0, cause bit2 = 0, and the exponent field bits[12:8] = 20. `wd_irq` and `wd_rst` are low.
- R2: A write with bit0 = 1 sets the enable bit. A write with bit0 = 0 leaves it set. Only `rst_n` clears it.
- R3: While enable is 0, a write loads bits[12:8] into the exponent N, and this includes the write that sets enable. While enable is 1, writes leave N unchanged.
- R4: The counter runs only while the block is enabled. The first expiry comes 2^N clock edges after the edge that captured the enabling write. At that expiry state bit1 becomes 1, and `wd_irq` (level mode) follows the state bit.
- R5: Writing 1 to bit1 clears the state bit and drops `wd_irq`. The counter keeps running and is not restarted.
- R6: An expiry while the state bit is set raises `wd_rst` for exactly 32 cycles, and clears the state bit in the same edge.
- R7: If the state bit is cleared before the next expiry, no reset follows. That expiry sets the state bit again, as a fresh warning.
- R8: A one-cycle `kick` pulse restarts the counter from zero. Kicks spaced fewer than 2^N cycles apart prevent any expiry.
- R9: When `wd_rst` falls, the counter restarts from zero, and the next warning comes 2^N edges after the edge where `wd_rst` fell.
- R10: Cause bit2 becomes 1 when the watchdog reset is issued. It stays 1 after the pulse ends. Writing 1 to bit2 clears it, and so does `rst_n`.
- R11: While enable is 0, no expiry occurs: `wd_irq` and `wd_rst` stay low, and the state bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data: bit0 enable, bit1 clear state, bit2 clear cause, bits[12:8] exponent |
| kick | input | 1 | One-cycle restart pulse from the command channel |
| rd_data | output | 16 | Current control and status word |
| wd_irq | output | 1 | Warning interrupt |
| wd_rst | output | 1 | Reset request to the core, held for 32 cycles |

## Verification
The hardest state to reach from the ports is the second expiry and what follows it. An uncleared warning must turn into a reset pulse of exact length, and the counter must then restart cleanly. The bench reaches it by programming small exponents (0, 1, 3, 5, 7) so that each run of two full timeouts plus the pulse stays short. It then counts edges from warning to reset, through the pulse, and back to the next warning. Further directed sequences clear the warning just after it rises, and keep the counter from expiring by kicking it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Control/status word bit positions
   localparam int EN_POS    = 0;
   localparam int STATE_POS = 1;
   localparam int CAUSE_POS = 2;
   localparam int EXP_LSB   = 8;

   // Mask of ones below bit n, used as the terminal count of a 2^n period
   function automatic logic [63:0] low_ones(input int unsigned n);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < int'(n)) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
   parameter int CNT_W = 32,
   parameter int EXP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             kick_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit    = ~({CNT_W{1'b1}} << exp_i);
   assign expire_o = run_i && !kick_i && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || kick_i || expire_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit);
   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
   parameter int EXP_W   = 5,
   parameter int EXP_RST = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             set_en_i,
   input  logic             clr_state_i,
   input  logic             clr_cause_i,
   input  logic [EXP_W-1:0] exp_wr_i,
   input  logic             expire_i,
   input  logic             fire_i,
   output logic             en_o,
   output logic             state_o,
   output logic             cause_o,
   output logic [EXP_W-1:0] exp_o
);
   logic             en_q, state_q, cause_q;
   logic [EXP_W-1:0] exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         state_q <= 1'b0;
         cause_q <= 1'b0;
         exp_q   <= EXP_W'(EXP_RST);
      end else begin
         if (wr_en_i && set_en_i) en_q <= 1'b1;
         if (wr_en_i && !en_q)    exp_q <= exp_wr_i;

         if (fire_i)                      state_q <= 1'b0;
         else if (expire_i)               state_q <= 1'b1;
         else if (wr_en_i && clr_state_i) state_q <= 1'b0;

         if (fire_i)                      cause_q <= 1'b1;
         else if (wr_en_i && clr_cause_i) cause_q <= 1'b0;
      end
   end

   assign en_o    = en_q;
   assign state_o = state_q;
   assign cause_o = cause_q;
   assign exp_o   = exp_q;

   p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);
   p_exp_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(exp_q));
   p_state_off_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !state_q);
   p_cause_after_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> cause_q);
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
   parameter int RST_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic active_o
);
   localparam int RC_W = (RST_LEN > 2) ? $clog2(RST_LEN) : 1;
   localparam logic [RC_W-1:0] LAST = RC_W'(RST_LEN - 1);

   logic            active_q;
   logic [RC_W-1:0] rcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rcnt_q   <= '0;
      end else if (fire_i && !active_q) begin
         active_q <= 1'b1;
         rcnt_q   <= '0;
      end else if (active_q) begin
         if (rcnt_q == LAST) begin
            active_q <= 1'b0;
            rcnt_q   <= '0;
         end else begin
            rcnt_q <= rcnt_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;

   p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> ($past(rcnt_q) == LAST));
   p_no_refire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> !fire_i);
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual #(
   parameter int CNT_W     = 32,
   parameter int EXP_W     = 5,
   parameter int EXP_RST   = 20,
   parameter int RST_LEN   = 32,
   parameter int REG_W     = 16,
   parameter bit IRQ_PULSE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             kick,
   output logic [REG_W-1:0] rd_data,
   output logic             wd_irq,
   output logic             wd_rst
);
   import wdog_pkg::*;

   localparam int MAX_EXP = (1 << EXP_W) - 1;

   if (CNT_W < MAX_EXP) begin : g_bad_cnt
      $error("CNT_W must cover the largest exponent");
   end
   if (REG_W < EXP_LSB + EXP_W) begin : g_bad_reg
      $error("REG_W too narrow for the exponent field");
   end
   if (RST_LEN < 2) begin : g_bad_len
      $error("RST_LEN must be at least 2");
   end
   if (EXP_RST > MAX_EXP) begin : g_bad_def
      $error("EXP_RST does not fit the exponent field");
   end

   logic             en, st, cause, expire, fire, rst_act, run;
   logic [EXP_W-1:0] exp_val;

   assign run  = en && !rst_act;
   assign fire = expire && st;

   wdog_timebase #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run_i(run), .kick_i(kick),
      .exp_i(exp_val), .expire_o(expire)
   );

   wdog_regs #(.EXP_W(EXP_W), .EXP_RST(EXP_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en),
      .set_en_i(wr_data[EN_POS]), .clr_state_i(wr_data[STATE_POS]),
      .clr_cause_i(wr_data[CAUSE_POS]),
      .exp_wr_i(wr_data[EXP_LSB +: EXP_W]),
      .expire_i(expire), .fire_i(fire),
      .en_o(en), .state_o(st), .cause_o(cause), .exp_o(exp_val)
   );

   wdog_rstgen #(.RST_LEN(RST_LEN)) u_rg (
      .clk(clk), .rst_n(rst_n), .fire_i(fire), .active_o(rst_act)
   );

   if (IRQ_PULSE) begin : g_irq_pulse
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= expire && !st;
      end
      assign wd_irq = irq_q;
   end else begin : g_irq_level
      assign wd_irq = st;
   end

   always_comb begin
      rd_data                     = '0;
      rd_data[EN_POS]             = en;
      rd_data[STATE_POS]          = st;
      rd_data[CAUSE_POS]          = cause;
      rd_data[EXP_LSB +: EXP_W]   = exp_val;
   end

   assign wd_rst = rst_act;

   p_warn_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> $past(st));
   p_cause_on_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |-> cause || $past(wr_en && wr_data[CAUSE_POS]));
   p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !expire);
endmodule

// File: tb/sim_wdog_dual.sv
module sim_wdog_dual;
   localparam int CLK_P = 10;
   localparam int NTAB  = 5;
   localparam int TAB_N [NTAB] = '{0, 1, 3, 5, 7};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        kick = 1'b0;
   logic [15:0] rd_data;
   logic        wd_irq, wd_rst;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   wdog_dual u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .kick(kick), .rd_data(rd_data), .wd_irq(wd_irq), .wd_rst(wd_rst)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sys_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic reg_write(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   // which: 0 = wd_irq, 1 = wd_rst; counts posedges until it reaches level
   task automatic edges_until(input int which, input logic level, output int n);
      n = 0;
      for (int k = 0; k < 5000; k++) begin
         @(posedge clk);
         #1;
         n++;
         if (((which == 0) ? wd_irq : wd_rst) == level) return;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog timeout of the bench");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      sys_reset();
      #1;
      // R1 reset view
      chk("R1 rd_data", rd_data, 16'h1400);
      chk("R1 wd_irq", wd_irq, 0);
      chk("R1 wd_rst", wd_rst, 0);

      // Table walk: full warn / reset / recover cycle per exponent
      for (int t = 0; t < NTAB; t++) begin
         sys_reset();
         reg_write(16'((TAB_N[t] << 8) | 1));
         edges_until(0, 1'b1, n);
         chk("R4 first expiry edges", n, 1 << TAB_N[t]);
         chk("R4 state bit", rd_data[1], 1);
         edges_until(1, 1'b1, n);
         chk("R6 reset after second expiry", n, 1 << TAB_N[t]);
         chk("R6 state cleared at reset", rd_data[1], 0);
         chk("R10 cause set", rd_data[2], 1);
         edges_until(1, 1'b0, n);
         chk("R6 reset length", n, 32);
         chk("R10 cause persists", rd_data[2], 1);
         edges_until(0, 1'b1, n);
         chk("R9 warn after reset", n, 1 << TAB_N[t]);
      end

      // R10 write-one clears cause; system reset clears it too
      reg_write(16'h0004);
      #1;
      chk("R10 cause w1c", rd_data[2], 0);
      sys_reset();
      reg_write(16'h0001);
      edges_until(1, 1'b1, n);
      edges_until(1, 1'b0, n);
      sys_reset();
      #1;
      chk("R10 cause cleared by rst_n", rd_data[2], 0);

      // R2 / R3 / R11
      sys_reset();
      reg_write(16'h0100);
      #1;
      chk("R3 exponent load while off", rd_data, 16'h0100);
      repeat (50) @(negedge clk);
      chk("R11 no irq while off", wd_irq, 0);
      chk("R11 state stays 0", rd_data[1], 0);
      reg_write(16'h0301);
      reg_write(16'h0F00);
      #1;
      chk("R2 enable stays set", rd_data[0], 1);
      chk("R3 exponent locked", rd_data[12:8], 3);

      // R5 / R7 clear warning in time
      sys_reset();
      reg_write(16'h0301);
      edges_until(0, 1'b1, n);
      reg_write(16'h0002);
      #1;
      chk("R5 irq dropped by clear", wd_irq, 0);
      chk("R5 state cleared", rd_data[1], 0);
      edges_until(0, 1'b1, n);
      chk("R5 counter not restarted", n, 7);
      chk("R7 no reset after clear", wd_rst, 0);
      chk("R7 fresh warning", rd_data[1], 1);

      // R8 kicks hold off expiry
      sys_reset();
      reg_write(16'h0301);
      for (int k = 0; k < 10; k++) begin
         repeat (5) @(negedge clk);
         kick = 1'b1;
         @(negedge clk);
         kick = 1'b0;
      end
      chk("R8 no irq with kicks", wd_irq, 0);
      chk("R8 state stays 0", rd_data[1], 0);
      edges_until(0, 1'b1, n);
      chk("R8 restart from kick", n, 8);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule